// File: doc/BRIEF.md
# Receive/transmit FIFO line status and interrupt identifier

This block collects the state of a serial port's receive and transmit FIFOs into an 8-bit line status word and an 8-bit interrupt identification word, and it drives one interrupt line. The FIFOs, the character timer and the register bus decoding sit outside the block. The block receives the receive FIFO occupancy, the error flags of the entry at the head of the FIFO and of the entry being written, the trigger-level and character-timeout flags, the transmit empty flags and a transmit interrupt request that is kept outside the block. It also receives three interrupt enables: receive data, transmit empty and line status.

Two conditions share the receive-data priority slot: trigger level reached and character timeout. When the receive data enable is cleared, the receiver is in polled mode. In polled mode the status word still reports data, but no trigger or timeout code is shown. The transmitter moves to polled mode on its own through its own enable. The block keeps a count of the FIFO entries that carry an error. This count rises as errored characters are written and falls as they are read out, and it drives the summary error bit.

Top module: `fifo_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly when the receive count is nonzero.
- R2: Status bit 5 equals the transmit FIFO empty flag. Status bit 6 is 1 only when both the transmit FIFO and the shift register are empty.
- R3: With FIFOs enabled, status bit 7 is 1 while any entry in the receive FIFO carries an error. A write with any error flag adds one entry to the count, and a read whose head entry has any flag removes one. The bit is 0 after reset and while FIFOs are disabled.
- R4: Status bits 2, 3 and 4 show the head entry's parity, framing and break flags (input bits 0, 1 and 2) while data is ready. When no data is ready they are 0.
- R5: Status bit 1 (overrun) is set one cycle after an overrun pulse. It stays set until the cycle after a status read that has no new overrun pulse.
- R6: With the line status enable set, an overrun or a head entry error gives identification code 6 (low nibble). This code has the highest priority.
- R7: With the receive enable set and FIFOs enabled, trigger reached gives code 4 and timeout alone gives code 12. With FIFOs disabled, data ready gives code 4. These codes rank below 6 and above 2.
- R8: With the transmit enable set, a pending transmit request gives code 2. This is the lowest priority.
- R9: Code 1 means nothing is pending. The interrupt line is high exactly when bit 0 of the code is 0.
- R10: With the receive enable cleared, neither trigger nor timeout shows in the code, while status bit 0 still tracks the count. The transmit side is unaffected.
- R11: Identification bits 7 and 6 both equal the FIFO enable. Bits 5 and 4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| ier_rx | input | 1 | Receive data interrupt enable |
| ier_tx | input | 1 | Transmit empty interrupt enable |
| ier_ls | input | 1 | Line status interrupt enable |
| rx_count | input | CW | Receive FIFO occupancy |
| rx_push | input | 1 | Character written to receive FIFO |
| rx_push_err | input | 3 | Error flags of written character {break, framing, parity} |
| rx_pop | input | 1 | Character read from receive FIFO |
| rx_head_err | input | 3 | Error flags of head entry {break, framing, parity} |
| rx_overrun | input | 1 | Overrun pulse |
| rx_trig | input | 1 | Trigger level reached |
| rx_timeout | input | 1 | Character timeout flag |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| thre_req | input | 1 | Transmit empty interrupt request |
| lsr_rd | input | 1 | Line status read strobe |
| lsr | output | 8 | Line status word |
| iir | output | 8 | Interrupt identification word |
| irq | output | 1 | Interrupt line |

## Verification
The code is driven with single sources, then with sources stacked two and three deep, so that each priority comparison is observed. Trigger and timeout are raised together and separately, which shows the order inside the shared receive slot. The error count is exercised by writing clean and errored characters in a mix and then reading them out one at a time. This shows that bit 7 stays set until the last errored entry leaves, and that a clean read leaves the bit alone. Clearing one enable at a time shows that the directions enter polled mode independently.

// File: rtl/fifo_line_status.sv
module fifo_line_status #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          ier_rx,
  input  logic          ier_tx,
  input  logic          ier_ls,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_push,
  input  logic [2:0]    rx_push_err,
  input  logic          rx_pop,
  input  logic [2:0]    rx_head_err,
  input  logic          rx_overrun,
  input  logic          rx_trig,
  input  logic          rx_timeout,
  input  logic          tx_fifo_empty,
  input  logic          tx_shift_empty,
  input  logic          thre_req,
  input  logic          lsr_rd,
  output logic [7:0]    lsr,
  output logic [7:0]    iir,
  output logic          irq
);

  logic [CW-1:0] err_cnt;
  logic          ovr;
  logic [3:0]    code;

  wire dr     = rx_count != '0;
  wire inc    = rx_push && (|rx_push_err);
  wire dec    = rx_pop && (|rx_head_err) && (err_cnt != '0);
  wire ls_err = ovr || (dr && (|rx_head_err));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       err_cnt <= '0;
    else if (!fifo_en) err_cnt <= '0;
    else               err_cnt <= err_cnt + CW'(inc) - CW'(dec);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          ovr <= 1'b0;
    else if (rx_overrun) ovr <= 1'b1;
    else if (lsr_rd)     ovr <= 1'b0;

  always_comb begin
    code = 4'h1;
    if (ier_tx && thre_req) code = 4'h2;
    if (ier_rx) begin
      if (fifo_en) begin
        if (rx_timeout) code = 4'hC;
        if (rx_trig)    code = 4'h4;
      end else if (dr) begin
        code = 4'h4;
      end
    end
    if (ier_ls && ls_err) code = 4'h6;
  end

  assign lsr = {fifo_en && (err_cnt != '0), tx_fifo_empty && tx_shift_empty,
                tx_fifo_empty, dr ? rx_head_err : 3'b000, ovr, dr};
  assign iir = {fifo_en, fifo_en, 2'b00, code};
  assign irq = !code[0];

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= CW'(DEPTH));
  a_r3_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && inc |=> !fifo_en || lsr[7]);
  a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !fifo_en || !lsr[7] || $past(inc));
  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> lsr[1]);
  a_r5_ovr_clr: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_overrun |=> !lsr[1]);
  a_r6_ls_top: assert property (@(posedge clk) disable iff (!rst_n)
    ier_ls && lsr[1] |-> iir[3:0] == 4'h6);
  a_r10_polled: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_rx |-> iir[3:0] != 4'h4 && iir[3:0] != 4'hC);
  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_rx && !ier_tx && !ier_ls |-> !irq);

endmodule

// File: tb/test_fifo_line_status.sv
module test_fifo_line_status;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, ier_rx = 0, ier_tx = 0, ier_ls = 0;
  logic [CW-1:0] rx_count = '0;
  logic rx_push = 0, rx_pop = 0, rx_overrun = 0, rx_trig = 0, rx_timeout = 0;
  logic [2:0] rx_push_err = 0, rx_head_err = 0;
  logic tx_fifo_empty = 1, tx_shift_empty = 1, thre_req = 0, lsr_rd = 0;
  logic [7:0] lsr, iir;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fifo_line_status #(.DEPTH(DEPTH)) i_fifo_line_status (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic settle; @(negedge clk); #1; endtask
  task automatic tick;   @(negedge clk); endtask

  task automatic t_reset;
    chk("R3 reset", lsr[7], 0);
    chk("R5 reset", lsr[1], 0);
    chk("R9 reset code", iir[3:0], 1);
    chk("R9 reset irq", irq, 0);
    chk("R11 fifo bits", iir[7:4], 4'hC);
  endtask

  task automatic t_status;
    rx_count = 3; rx_head_err = 3'b101; tx_fifo_empty = 0; tx_shift_empty = 1; #1;
    chk("R1 data ready", lsr[0], 1);
    chk("R4 head errs", lsr[4:2], 3'b101);
    chk("R2 thre low", lsr[6:5], 0);
    tx_fifo_empty = 1; tx_shift_empty = 0; #1;
    chk("R2 thre only", lsr[6:5], 2'b01);
    tx_shift_empty = 1; #1;
    chk("R2 temt", lsr[6:5], 2'b11);
    rx_count = 0; #1;
    chk("R1 empty", lsr[0], 0);
    chk("R4 hidden", lsr[4:2], 0);
    rx_head_err = 0;
  endtask

  task automatic t_errfifo;
    tick(); rx_push = 1; rx_push_err = 3'b010; tick();
    rx_push_err = 3'b000; tick();
    rx_push_err = 3'b001; tick();
    rx_push = 0; rx_push_err = 0; #1;
    chk("R3 two errored", lsr[7], 1);
    rx_count = 3; rx_pop = 1; rx_head_err = 3'b010; tick(); #1;
    chk("R3 one left", lsr[7], 1);
    rx_head_err = 0; tick(); #1;
    chk("R3 clean read", lsr[7], 1);
    rx_head_err = 3'b001; tick(); #1;
    chk("R3 drained", lsr[7], 0);
    rx_pop = 0; rx_head_err = 0; rx_count = 0;
    rx_push = 1; rx_push_err = 3'b100; rx_pop = 1; rx_head_err = 3'b100; tick();
    rx_push = 0; rx_pop = 0; rx_push_err = 0; rx_head_err = 0; #1;
    chk("R3 push+pop", lsr[7], 1);
    fifo_en = 0; tick(); #1;
    chk("R3 disabled clears", lsr[7], 0);
    chk("R11 off", iir[7:6], 0);
    fifo_en = 1; tick(); #1;
    chk("R3 stays clear", lsr[7], 0);
  endtask

  task automatic t_overrun;
    rx_overrun = 1; tick(); rx_overrun = 0; #1;
    chk("R5 set", lsr[1], 1);
    tick(); #1;
    chk("R5 held", lsr[1], 1);
    lsr_rd = 1; rx_overrun = 1; tick(); rx_overrun = 0; #1;
    chk("R5 set wins", lsr[1], 1);
    tick(); lsr_rd = 0; #1;
    chk("R5 cleared", lsr[1], 0);
  endtask

  task automatic t_priority;
    ier_rx = 1; ier_tx = 1; ier_ls = 1;
    thre_req = 1; #1;
    chk("R8 thre", iir[3:0], 2);
    chk("R9 irq", irq, 1);
    rx_count = 1; rx_timeout = 1; #1;
    chk("R7 timeout", iir[3:0], 4'hC);
    rx_trig = 1; #1;
    chk("R7 trig over timeout", iir[3:0], 4);
    rx_head_err = 3'b001; #1;
    chk("R6 head err", iir[3:0], 6);
    ier_ls = 0; #1;
    chk("R6 disabled", iir[3:0], 4);
    rx_head_err = 0; rx_trig = 0; rx_timeout = 0; thre_req = 0; #1;
    chk("R9 none", iir[3:0], 1);
    chk("R9 irq low", irq, 0);
    fifo_en = 0; #1;
    chk("R7 no-fifo data", iir[3:0], 4);
    fifo_en = 1; rx_count = 0;
  endtask

  task automatic t_polled;
    ier_rx = 0; ier_tx = 1; rx_count = 5; rx_trig = 1; rx_timeout = 1; thre_req = 1; #1;
    chk("R10 tx still", iir[3:0], 2);
    chk("R10 dr shown", lsr[0], 1);
    thre_req = 0; #1;
    chk("R10 rx quiet", iir[3:0], 1);
    ier_rx = 1; ier_tx = 0; thre_req = 1; #1;
    chk("R10 tx polled", iir[3:0], 4);
    ier_rx = 0; rx_trig = 0; rx_timeout = 0; thre_req = 0; rx_count = 0;
  endtask

  initial begin
    #20; rst_n = 1; settle();
    t_reset(); t_status(); t_errfifo(); t_overrun(); t_priority(); t_polled();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; fails++; $display("FAIL watchdog"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule